// File: doc/BRIEF.md
# Recursive Power-Spectrum Bin Averager

This block smooths a stream of FFT power spectra bin by bin. Each update carries the squared real and squared imaginary parts of one frequency coefficient, the block exponent shared by the whole transform, and the address of the bin. The block adds the two squares and turns the power into a short float with a 6-bit exponent and a 5-bit mantissa. It reads the bin's stored filter word from a synchronous RAM port, scales that word, adds the new power and writes the result back to the same address. One update can be accepted on every clock.

Two averaging modes exist. In decay mode the stored value is weighted by one minus two to the power minus k, so the filter gain settles near 2^k. In integrate mode the powers simply accumulate. A per-update clear flag makes the write hold the new power alone, which is how a filter starts. The stored word keeps seven more mantissa bits than the raw power, so that the gain of 2^7 at k = 7 does not use up the precision. The RAM returns read data one clock after the read. Two updates to the same bin must therefore be at least three clocks apart; across successive frames this always holds.

Top module: `spec_avg`

## Requirements
- R1: When upd_valid_i is high, mem_rd_en_o is high in the same cycle with mem_rd_addr_o equal to bin_addr_i. Exactly two rising edges later, mem_wr_en_o is high for one cycle with mem_wr_addr_o equal to that address. There is no write in the cycle between and none when no update is given.
- R2: The power S is re_sq_i + im_sq_i (25 bits). When S < 32, the raw mantissa is S and the raw exponent is blk_exp_i.
- R3: When S >= 32 and the leading one of S sits at bit L, the raw mantissa is S[L:L-4] (lower bits truncated) and the raw exponent is blk_exp_i + L - 4.
- R4: A stored word has exponent E in bits [17:12] and mantissa M in bits [11:0], and it represents M·2^(E-7). A raw power with exponent e and mantissa m enters the sum as M = {m, 7'b0} with E = e.
- R5: With clear_bins_i high, the written word equals the widened raw power and ignores the stored word.
- R6: With integ_mode_i low (decay mode), the stored mantissa M becomes M - (M >> decay_k_i) before the add. For k = 0 the written word therefore equals the widened raw power.
- R7: With integ_mode_i high (integrate mode), the stored word is added without any scaling.
- R8: Both operands are aligned to the larger exponent. The operand with the smaller exponent is shifted right by the difference and truncated. An operand whose mantissa is zero takes no part in picking the exponent.
- R9: When the mantissa sum carries out of 12 bits, the written mantissa is the sum shifted right by one (the LSB is dropped) and the exponent goes up by one.
- R10: During and after reset, and before any update, mem_wr_en_o and mem_rd_en_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_valid_i | input | 1 | Bin update present this cycle |
| bin_addr_i | input | ADDR_W | Bin address of the update |
| re_sq_i | input | IN_W | Squared real part |
| im_sq_i | input | IN_W | Squared imaginary part |
| blk_exp_i | input | BEXP_W | Block exponent shared by the transform |
| integ_mode_i | input | 1 | 1 = integrate, 0 = decay |
| decay_k_i | input | K_W | Decay shift k |
| clear_bins_i | input | 1 | Store the new power alone |
| mem_rd_en_o | output | 1 | RAM read enable |
| mem_rd_addr_o | output | ADDR_W | RAM read address |
| mem_rd_data_i | input | 18 | RAM read data, one clock after the read |
| mem_wr_en_o | output | 1 | RAM write enable, registered |
| mem_wr_addr_o | output | ADDR_W | RAM write address |
| mem_wr_data_o | output | 18 | Updated filter word |

## Verification
The float conversion is tried on a zero power, on powers below 32 that stay unnormalized, on exact powers of two, on an irregular value whose low bits are truncated, and on the largest sum with a large block exponent. Together these separate the small-value path from the shifted path and check that the exponent offset is right. Repeated decay updates with k = 1, 3 and 0 tell a correct shift-and-subtract from a wrong shift amount and from an ignored k, and one of them forces a mantissa carry. Integrate updates check three cases: equal exponents that carry, an old value larger than the new one that must be truncated, and a new value far larger than the old one. Zero-mantissa operands show whether a zero takes part in picking the exponent.

// File: rtl/spec_avg_pkg.sv
package spec_avg_pkg;
  localparam int EXP_W   = 6;
  localparam int RAW_MW  = 5;
  localparam int GUARD_W = 7;
  localparam int ST_MW   = RAW_MW + GUARD_W;
  localparam int WORD_W  = EXP_W + ST_MW;

  typedef struct packed {
    logic [EXP_W-1:0]  e;
    logic [RAW_MW-1:0] m;
  } raw_flt_t;

  typedef struct packed {
    logic [EXP_W-1:0] e;
    logic [ST_MW-1:0] m;
  } st_flt_t;
endpackage

// File: rtl/spec_avg_pwr2flt.sv
module spec_avg_pwr2flt
  import spec_avg_pkg::*;
#(
  parameter int IN_W   = 24,
  parameter int BEXP_W = 5
) (
  input  logic [IN_W-1:0]   re_sq_i,
  input  logic [IN_W-1:0]   im_sq_i,
  input  logic [BEXP_W-1:0] bexp_i,
  output raw_flt_t          raw_o
);
  localparam int SUM_W = IN_W + 1;

  logic [SUM_W-1:0] pwr;
  int lead;
  int sh;

  always_comb begin
    pwr  = {1'b0, re_sq_i} + {1'b0, im_sq_i};
    lead = 0;
    for (int i = 0; i < SUM_W; i++) begin
      if (pwr[i]) lead = i;
    end
    // keep the top RAW_MW bits from the leading one, truncating the rest
    sh = (lead > RAW_MW - 1) ? lead - (RAW_MW - 1) : 0;
    raw_o.m = RAW_MW'(pwr >> sh);
    raw_o.e = EXP_W'(sh) + EXP_W'(bexp_i);
  end
endmodule

// File: rtl/spec_avg_decay_add.sv
module spec_avg_decay_add
  import spec_avg_pkg::*;
#(
  parameter int K_W = 3
) (
  input  st_flt_t        old_i,
  input  raw_flt_t       new_i,
  input  logic           integ_i,
  input  logic           clr_i,
  input  logic [K_W-1:0] k_i,
  output st_flt_t        res_o
);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  logic [ST_MW-1:0] sc_m, nw_m, al_o, al_n;
  logic [EXP_W-1:0] sc_e, ea;
  logic [ST_MW:0]   sum;

  always_comb begin
    nw_m = {new_i.m, {GUARD_W{1'b0}}};
    if (clr_i) begin
      sc_m = '0;
      sc_e = '0;
    end else begin
      sc_e = old_i.e;
      // (1 - 2^-k) as shift-and-subtract
      sc_m = integ_i ? old_i.m : old_i.m - (old_i.m >> k_i);
    end
    // a zero operand does not pull the exponent
    if (sc_m == '0)      ea = new_i.e;
    else if (nw_m == '0) ea = sc_e;
    else                 ea = (sc_e > new_i.e) ? sc_e : new_i.e;
    al_o = (sc_m == '0) ? '0 : sc_m >> (ea - sc_e);
    al_n = (nw_m == '0) ? '0 : nw_m >> (ea - new_i.e);
    sum  = {1'b0, al_o} + {1'b0, al_n};
    res_o.e = ea;
    res_o.m = sum[ST_MW-1:0];
    if (sum[ST_MW]) begin
      if (ea == EXP_MAX) begin
        res_o.m = '1;
      end else begin
        res_o.e = ea + 1'b1;
        res_o.m = sum[ST_MW:1];
      end
    end
  end
endmodule

// File: rtl/spec_avg.sv
module spec_avg
  import spec_avg_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int IN_W   = 24,
  parameter int BEXP_W = 5,
  parameter int K_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] bin_addr_i,
  input  logic [IN_W-1:0]   re_sq_i,
  input  logic [IN_W-1:0]   im_sq_i,
  input  logic [BEXP_W-1:0] blk_exp_i,
  input  logic              integ_mode_i,
  input  logic [K_W-1:0]    decay_k_i,
  input  logic              clear_bins_i,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic [WORD_W-1:0] mem_rd_data_i,
  output logic              mem_wr_en_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [WORD_W-1:0] mem_wr_data_o
);
  raw_flt_t          raw_c, s1_raw;
  st_flt_t           old_c, upd_c, wr_q;
  logic              s1_valid, s1_integ, s1_clr;
  logic [ADDR_W-1:0] s1_addr;
  logic [K_W-1:0]    s1_k;

  assign mem_rd_en_o   = upd_valid_i;
  assign mem_rd_addr_o = bin_addr_i;
  assign old_c         = st_flt_t'(mem_rd_data_i);

  spec_avg_pwr2flt #(.IN_W(IN_W), .BEXP_W(BEXP_W)) u_cvt (
    .re_sq_i (re_sq_i),
    .im_sq_i (im_sq_i),
    .bexp_i  (blk_exp_i),
    .raw_o   (raw_c)
  );

  // stage 1: converted power waits for the RAM read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      s1_raw   <= '0;
      s1_integ <= 1'b0;
      s1_k     <= '0;
      s1_clr   <= 1'b0;
    end else begin
      s1_valid <= upd_valid_i;
      s1_addr  <= bin_addr_i;
      s1_raw   <= raw_c;
      s1_integ <= integ_mode_i;
      s1_k     <= decay_k_i;
      s1_clr   <= clear_bins_i;
    end
  end

  spec_avg_decay_add #(.K_W(K_W)) u_upd (
    .old_i   (old_c),
    .new_i   (s1_raw),
    .integ_i (s1_integ),
    .clr_i   (s1_clr),
    .k_i     (s1_k),
    .res_o   (upd_c)
  );

  // stage 2: registered write-back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_wr_en_o   <= 1'b0;
      mem_wr_addr_o <= '0;
      wr_q          <= '0;
    end else begin
      mem_wr_en_o   <= s1_valid;
      mem_wr_addr_o <= s1_addr;
      wr_q          <= upd_c;
    end
  end

  assign mem_wr_data_o = wr_q;

  // R1
  wr_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_en_o == $past(upd_valid_i, 2));

  // R1
  wr_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_en_o |-> mem_wr_addr_o == $past(bin_addr_i, 2));

  // R7
  integ_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && s1_integ && !s1_clr && mem_rd_data_i[ST_MW-1:0] != '0)
    |=> mem_wr_data_o[WORD_W-1:ST_MW] >= $past(mem_rd_data_i[WORD_W-1:ST_MW]));

  // R5 R6
  pass_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && (s1_clr || (!s1_integ && s1_k == '0)))
    |=> mem_wr_data_o == $past({s1_raw.e, s1_raw.m, {GUARD_W{1'b0}}}));
endmodule

// File: tb/spec_avg_bench.sv
`timescale 1ns/1ps
module spec_avg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic [12:0] bin_addr = '0;
  logic [23:0] re_sq = '0, im_sq = '0;
  logic [4:0]  blk_exp = '0;
  logic        integ = 1'b0;
  logic [2:0]  dk = '0;
  logic        clr = 1'b0;
  logic        rd_en, wr_en;
  logic [12:0] rd_addr, wr_addr;
  logic [17:0] rd_q = '0;
  logic [17:0] wr_data;
  logic [17:0] ram [16];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  spec_avg u_spec_avg (
    .clk_i(clk), .rst_ni(rst_n), .upd_valid_i(upd_valid), .bin_addr_i(bin_addr),
    .re_sq_i(re_sq), .im_sq_i(im_sq), .blk_exp_i(blk_exp), .integ_mode_i(integ),
    .decay_k_i(dk), .clear_bins_i(clr), .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr),
    .mem_rd_data_i(rd_q), .mem_wr_en_o(wr_en), .mem_wr_addr_o(wr_addr),
    .mem_wr_data_o(wr_data)
  );

  always @(posedge clk) begin
    if (rd_en) rd_q <= ram[rd_addr[3:0]];
    if (wr_en) ram[wr_addr[3:0]] <= wr_data;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // re, im, bexp, raw exponent, raw mantissa
  localparam logic [63:0] VEC [7] = '{
    {24'd0,       24'd0,       5'd0,  6'd0,  5'd0 },
    {24'd3,       24'd4,       5'd2,  6'd2,  5'd7 },
    {24'd16,      24'd0,       5'd0,  6'd0,  5'd16},
    {24'd256,     24'd256,     5'd3,  6'd8,  5'd16},
    {24'hFFFFFF,  24'hFFFFFF,  5'd31, 6'd51, 5'd31},
    {24'd100,     24'd37,      5'd1,  6'd4,  5'd17},
    {24'd15,      24'd0,       5'd31, 6'd31, 5'd15}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic upd(input logic [3:0] bin, input logic [23:0] re, input logic [23:0] im,
                     input logic [4:0] be, input logic ig, input logic [2:0] k,
                     input logic cl, input logic [17:0] expw, input string tag);
    @(negedge clk);
    upd_valid = 1'b1; bin_addr = {9'd0, bin}; re_sq = re; im_sq = im;
    blk_exp = be; integ = ig; dk = k; clr = cl;
    #1;
    chk("R1 rd_en", 32'(rd_en), 32'd1);
    chk("R1 rd_addr", 32'(rd_addr), 32'(bin));
    @(posedge clk); @(negedge clk);
    upd_valid = 1'b0;
    chk("R1 early write", 32'(wr_en), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R1 wr_en", 32'(wr_en), 32'd1);
    chk("R1 wr_addr", 32'(wr_addr), 32'(bin));
    chk(tag, 32'(wr_data), 32'(expw));
    @(posedge clk); @(negedge clk);
    chk("R1 single write", 32'(wr_en), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ram[i] = '0;
    repeat (3) @(negedge clk);
    chk("R10 wr_en in reset", 32'(wr_en), 32'd0);
    chk("R10 rd_en in reset", 32'(rd_en), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 idle wr_en", 32'(wr_en), 32'd0);
    chk("R10 idle rd_en", 32'(rd_en), 32'd0);

    // R2 R3 R4 R5: conversion table, each stored with clear into its own bin
    for (int v = 0; v < 7; v++) begin
      upd(4'(8 + v), VEC[v][63:40], VEC[v][39:16], VEC[v][15:11], 1'b0, 3'd2, 1'b1,
          {VEC[v][10:5], VEC[v][4:0], 7'd0}, "R2 R3 R4 R5 conversion");
    end

    // R7 R9: integrate equal values, carry bumps the exponent
    upd(4'd1, 24'd16, 24'd0, 5'd0, 1'b0, 3'd0, 1'b1, {6'd0, 12'h800}, "R5 clear");
    upd(4'd1, 24'd16, 24'd0, 5'd0, 1'b1, 3'd0, 1'b0, {6'd1, 12'h800}, "R7 R9 integ carry");

    // R6: decay k=1, k=1, k=3 (carry), k=0
    upd(4'd2, 24'd256, 24'd256, 5'd3, 1'b0, 3'd5, 1'b1, {6'd8, 12'h800}, "R5 clear");
    upd(4'd2, 24'd256, 24'd256, 5'd3, 1'b0, 3'd1, 1'b0, {6'd8, 12'hC00}, "R6 decay k1");
    upd(4'd2, 24'd256, 24'd256, 5'd3, 1'b0, 3'd1, 1'b0, {6'd8, 12'hE00}, "R6 decay k1 again");
    upd(4'd2, 24'd256, 24'd256, 5'd3, 1'b0, 3'd3, 1'b0, {6'd9, 12'hA20}, "R6 R9 decay k3 carry");
    upd(4'd2, 24'd256, 24'd256, 5'd3, 1'b0, 3'd0, 1'b0, {6'd8, 12'h800}, "R6 decay k0");

    // R8: alignment both ways
    upd(4'd3, 24'd256, 24'd256, 5'd3, 1'b1, 3'd0, 1'b1, {6'd8, 12'h800}, "R5 clear");
    upd(4'd3, 24'd16, 24'd0, 5'd0, 1'b1, 3'd0, 1'b0, {6'd8, 12'h808}, "R8 smaller new");
    upd(4'd3, 24'hFFFFFF, 24'hFFFFFF, 5'd31, 1'b1, 3'd0, 1'b0, {6'd51, 12'hF80},
        "R8 larger new");

    // R8: zero mantissa does not set the exponent
    upd(4'd4, 24'd0, 24'd0, 5'd31, 1'b1, 3'd0, 1'b1, {6'd31, 12'h000}, "R5 clear zero");
    upd(4'd4, 24'd16, 24'd0, 5'd0, 1'b1, 3'd0, 1'b0, {6'd0, 12'h800}, "R8 zero old");
    upd(4'd4, 24'd0, 24'd0, 5'd31, 1'b1, 3'd0, 1'b0, {6'd0, 12'h800}, "R8 zero new");

    // R5: clear ignores a nonzero stored word
    upd(4'd2, 24'd3, 24'd4, 5'd2, 1'b1, 3'd0, 1'b1, {6'd2, 12'h380}, "R5 clear over old");

    repeat (2) @(negedge clk);
    chk("R1 no write when idle", 32'(wr_en), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule